// File: doc/BRIEF.md
# Bus Access Timeout Monitor

This block sits beside a peripheral register bus that allows one access in flight at a time. It counts clock cycles from the moment a request is accepted until the slave answers. If the count reaches a programmable threshold first, the monitor ends the access itself by returning an error response to the master. It then raises a level interrupt and keeps the address and the originator tag of the stalled access for software to inspect.

Software controls the block through a small word-addressed register port. Word 0 is the control word: a 16-bit threshold in bits [15:0], a clear strobe in bit 16 and an enable in bit 17. Word 1 returns the captured address and word 2 returns the captured 7-bit tag. Slave responses reach the master through the monitor. Once an access has been ended by the monitor, any later answer from the slave for that access is dropped.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset the interrupt is low, word 0 reads 0x0002FFFF (threshold 65535, enable set, clear bit 0), and words 1 and 2 read 0.
- R2: With threshold T and enable set, a request accepted at a clock edge and left unanswered produces a forced response (m_rsp_valid=1, m_rsp_err=1) in the cycle that follows the T-th edge after the acceptance edge. The first cycle after acceptance counts as cycle 0.
- R3: A threshold of 0 forces the error response in the first cycle after the request is accepted.
- R4: A slave response that arrives in cycle d < T is passed to the master in that same cycle with the slave's error flag, and the interrupt stays low.
- R5: The forced error lasts exactly one cycle. A slave response arriving in the timeout cycle or later, for the same access, does not reach the master.
- R6: With enable (bit 17 of word 0) cleared, no timeout is ever raised. Slave responses still pass through.
- R7: On a timeout, word 1 holds the full 32-bit request address, and word 2 holds the master ID in bits [4:0] and the privilege in bits [6:5].
- R8: The interrupt is a level that stays high until a write to word 0 with bit 16 set. Bit 16 always reads back as 0.
- R9: Clearing the interrupt returns words 1 and 2 to 0.
- R10: While the interrupt is pending, a further timeout still forces an error response but leaves the captured address and tag unchanged.
- R11: A new request restarts the count from cycle 0, even if an earlier access is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the monitored domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request accepted on the bus this cycle |
| req_addr | input | 32 | Address of the accepted request |
| req_master | input | 5 | Originator ID of the request |
| req_priv | input | 2 | Privilege level of the request |
| s_rsp_valid | input | 1 | Response from the slave |
| s_rsp_err | input | 1 | Error flag of the slave response |
| m_rsp_valid | output | 1 | Response delivered to the master |
| m_rsp_err | output | 1 | Error flag delivered to the master |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word index, for both read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected word |
| irq | output | 1 | Timeout interrupt, level |

## Verification
The assertions assume the bus follows its own protocol. The slave answers only an access that is still outstanding, req_valid is a single-cycle event for each access, and register writes are single-cycle strobes. The stimulus keeps to these rules by design. Every request is one cycle wide, and the slave is driven at most once per access. The only extra drive is a deliberate late answer, used to show that a stale reply is dropped.

// File: rtl/bto_pkg.sv
package bto_pkg;
   // Word indices of the register port
   typedef enum logic [1:0] {
      WORD_CTRL = 2'd0,
      WORD_ADDR = 2'd1,
      WORD_TAG  = 2'd2,
      WORD_NONE = 2'd3
   } word_e;

   // Bit positions inside the control word (software visible)
   localparam int unsigned CLR_POS = 16;
   localparam int unsigned EN_POS  = 17;
endpackage

// File: rtl/bto_tracker.sv
module bto_tracker #(
   parameter int unsigned THR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             rsp_in,
   input  logic [THR_W-1:0] thr,
   input  logic             en,
   output logic             fire,
   output logic             rsp_pass
);
   localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

   logic             busy;
   logic [THR_W-1:0] cnt;

   assign fire     = busy && en && (cnt == thr);
   assign rsp_pass = busy && rsp_in && !fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (req_valid) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy && (fire || rsp_in)) begin
         busy <= 1'b0;
      end else if (busy && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R5: a forced error is a single-cycle event unless a new access starts
   p_single_forced_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_valid) |=> !fire);

   // R5: nothing reaches the master once the access has ended
   p_idle_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req_valid) |=> !rsp_pass);
endmodule

// File: rtl/bto_capture.sv
module bto_capture #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned TAG_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              fire,
   input  logic              clr,
   output logic              irq,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [TAG_W-1:0]  cap_tag
);
   logic [ADDR_W-1:0] fly_addr;
   logic [TAG_W-1:0]  fly_tag;
   logic              take;

   // A fault is recorded only when no earlier one is kept
   assign take = fire && (!irq || clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fly_addr <= '0;
         fly_tag  <= '0;
      end else if (req_valid) begin
         fly_addr <= req_addr;
         fly_tag  <= req_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         cap_addr <= '0;
         cap_tag  <= '0;
      end else if (take) begin
         irq      <= 1'b1;
         cap_addr <= fly_addr;
         cap_tag  <= fly_tag;
      end else if (clr) begin
         irq      <= 1'b0;
         cap_addr <= '0;
         cap_tag  <= '0;
      end
   end

   p_irq_level_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);

   p_first_kept_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> ($stable(cap_addr) && $stable(cap_tag)));

   p_clear_wipes_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fire) |=> (!irq && cap_addr == '0 && cap_tag == '0));
endmodule

// File: rtl/bto_cfg.sv
module bto_cfg
   import bto_pkg::*;
#(
   parameter int unsigned  ADDR_W  = 32,
   parameter int unsigned  TAG_W   = 7,
   parameter int unsigned  THR_W   = 16,
   parameter int unsigned  DATA_W  = 32,
   parameter logic [THR_W-1:0] THR_RST = {THR_W{1'b1}},
   parameter logic         EN_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic [TAG_W-1:0]  cap_tag,
   output logic [THR_W-1:0]  thr,
   output logic              en,
   output logic              clr,
   output logic [DATA_W-1:0] rdata
);
   logic ctrl_hit;

   assign ctrl_hit = wr && (word_e'(addr) == WORD_CTRL);
   assign clr      = ctrl_hit && wdata[CLR_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr <= THR_RST;
         en  <= EN_RST;
      end else if (ctrl_hit) begin
         thr <= wdata[THR_W-1:0];
         en  <= wdata[EN_POS];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (word_e'(addr))
         WORD_CTRL: begin
            rdata[THR_W-1:0] = thr;
            rdata[EN_POS]    = en;
         end
         WORD_ADDR: rdata[ADDR_W-1:0] = cap_addr;
         WORD_TAG:  rdata[TAG_W-1:0]  = cap_tag;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
   import bto_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ID_W   = 5,
   parameter int unsigned PRIV_W = 2,
   parameter int unsigned THR_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter logic        EN_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_master,
   input  logic [PRIV_W-1:0] req_priv,
   input  logic              s_rsp_valid,
   input  logic              s_rsp_err,
   output logic              m_rsp_valid,
   output logic              m_rsp_err,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              irq
);
   localparam int unsigned TAG_W = ID_W + PRIV_W;
   localparam logic [THR_W-1:0] THR_RST = {THR_W{1'b1}};

   if (THR_W < 1 || THR_W > CLR_POS) begin : g_bad_thr
      $error("THR_W must lie in 1..16 so it fits below the clear bit");
   end
   if (ADDR_W > DATA_W || TAG_W > DATA_W || DATA_W <= EN_POS) begin : g_bad_width
      $error("captured fields and control bits must fit in DATA_W");
   end

   logic [THR_W-1:0]  thr;
   logic              cfg_en;
   logic              clr;
   logic              fire;
   logic              rsp_pass;
   logic [ADDR_W-1:0] cap_addr;
   logic [TAG_W-1:0]  cap_tag;

   bto_tracker #(.THR_W(THR_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .rsp_in   (s_rsp_valid),
      .thr      (thr),
      .en       (cfg_en),
      .fire     (fire),
      .rsp_pass (rsp_pass)
   );

   bto_capture #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_addr (req_addr),
      .req_tag  ({req_priv, req_master}),
      .fire     (fire),
      .clr      (clr),
      .irq      (irq),
      .cap_addr (cap_addr),
      .cap_tag  (cap_tag)
   );

   bto_cfg #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W),
      .THR_W  (THR_W),
      .DATA_W (DATA_W),
      .THR_RST(THR_RST),
      .EN_RST (EN_RST)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .cap_addr(cap_addr),
      .cap_tag (cap_tag),
      .thr     (thr),
      .en      (cfg_en),
      .clr     (clr),
      .rdata   (cfg_rdata)
   );

   assign m_rsp_valid = rsp_pass || fire;
   assign m_rsp_err   = fire || (rsp_pass && s_rsp_err);

   p_disabled_silent_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !s_rsp_valid) |-> !m_rsp_valid);
endmodule

// File: tb/bus_timeout_monitor_tb.sv
module bus_timeout_monitor_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [4:0]  req_master = '0;
   logic [1:0]  req_priv = '0;
   logic        s_rsp_valid = 1'b0;
   logic        s_rsp_err = 1'b0;
   logic        m_rsp_valid;
   logic        m_rsp_err;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bus_timeout_monitor u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr),
      .req_master(req_master), .req_priv(req_priv),
      .s_rsp_valid(s_rsp_valid), .s_rsp_err(s_rsp_err),
      .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [15:0] thr;
      logic        en;
      logic [7:0]  dly;    // slave answers in this cycle (0 = first after request)
      logic        serr;
      logic [31:0] addr;
      logic [4:0]  mid;
      logic [1:0]  priv;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{16'd4,  1'b1, 8'd10, 1'b0, 32'h4000_1000, 5'd3,  2'd1},
      '{16'd0,  1'b1, 8'd5,  1'b0, 32'hDEAD_BEE0, 5'd31, 2'd3},
      '{16'd6,  1'b1, 8'd2,  1'b0, 32'h1234_5678, 5'd7,  2'd0},
      '{16'd6,  1'b1, 8'd3,  1'b1, 32'h8000_0004, 5'd1,  2'd2},
      '{16'd5,  1'b1, 8'd5,  1'b0, 32'hFFFF_FFFC, 5'd16, 2'd1},
      '{16'd3,  1'b0, 8'd9,  1'b1, 32'h0000_0040, 5'd9,  2'd2},
      '{16'd1,  1'b1, 8'd30, 1'b0, 32'hA5A5_5A5A, 5'd21, 2'd3},
      '{16'd12, 1'b1, 8'd11, 1'b0, 32'h0BAD_F00D, 5'd0,  2'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = '0;
   endtask

   task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic send_req(input logic [31:0] a, input logic [4:0] m, input logic [1:0] p);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_master = m; req_priv = p;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Waits from cycle 0 after the request; reports the first response seen
   task automatic watch(input int dly, input logic serr, input int lim,
                        output int seen_k, output logic seen_err);
      seen_k = -1; seen_err = 1'b0;
      for (int k = 0; k < lim; k++) begin
         s_rsp_valid = (k == dly); s_rsp_err = (k == dly) ? serr : 1'b0;
         #1;
         if (m_rsp_valid) begin
            seen_k = k; seen_err = m_rsp_err;
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      s_rsp_valid = 1'b0; s_rsp_err = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input logic [15:0] t, input logic e, input logic c);
      return {14'd0, e, c, t};
   endfunction

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int   k;
      logic e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cfg_read(2'd0, rd); check("R1 ctrl word", rd, 32'h0002_FFFF);
      cfg_read(2'd1, rd); check("R1 addr word", rd, 32'h0);
      cfg_read(2'd2, rd); check("R1 tag word", rd, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);

      // Vector table: R2 R3 R4 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         logic to;
         to = VECS[i].en && (32'(VECS[i].dly) >= 32'(VECS[i].thr));
         cfg_write(2'd0, ctrl_word(VECS[i].thr, VECS[i].en, 1'b1));
         send_req(VECS[i].addr, VECS[i].mid, VECS[i].priv);
         watch(VECS[i].dly, VECS[i].serr, 40, k, e);
         if (to) begin
            check("R2 R3 timeout cycle", 32'(k), 32'(VECS[i].thr));
            check("R2 forced error", {31'd0, e}, 32'd1);
         end else begin
            check("R4 R6 pass cycle", 32'(k), 32'(VECS[i].dly));
            check("R4 R6 slave err", {31'd0, e}, {31'd0, VECS[i].serr});
         end
         check("R8 irq level", {31'd0, irq}, {31'd0, to});
         cfg_read(2'd1, rd); check("R7 captured addr", rd, to ? VECS[i].addr : 32'h0);
         cfg_read(2'd2, rd); check("R7 captured tag", rd, to ? {25'd0, VECS[i].priv, VECS[i].mid} : 32'h0);
         cfg_read(2'd0, rd); check("R8 clear bit reads 0", rd, ctrl_word(VECS[i].thr, VECS[i].en, 1'b0));
         cfg_write(2'd0, ctrl_word(VECS[i].thr, VECS[i].en, 1'b1));
         check("R9 irq cleared", {31'd0, irq}, 32'h0);
         cfg_read(2'd1, rd); check("R9 addr wiped", rd, 32'h0);
         cfg_read(2'd2, rd); check("R9 tag wiped", rd, 32'h0);
      end

      // R5 late response dropped, single-cycle forced error
      cfg_write(2'd0, ctrl_word(16'd2, 1'b1, 1'b1));
      send_req(32'h0000_1111, 5'd2, 2'd1);
      watch(99, 1'b0, 10, k, e);
      check("R5 fire cycle", 32'(k), 32'd2);
      s_rsp_valid = 1'b1;
      #1 check("R5 late rsp dropped", {31'd0, m_rsp_valid}, 32'd0);
      @(negedge clk); s_rsp_valid = 1'b0;
      #1 check("R5 no repeat", {31'd0, m_rsp_valid}, 32'd0);

      // R10 first fault kept while pending
      send_req(32'h0000_2222, 5'd4, 2'd2);
      watch(99, 1'b0, 10, k, e);
      check("R10 second still forced", {31'd0, e}, 32'd1);
      cfg_read(2'd1, rd); check("R10 first addr kept", rd, 32'h0000_1111);
      cfg_read(2'd2, rd); check("R10 first tag kept", rd, {25'd0, 2'd1, 5'd2});
      cfg_write(2'd0, ctrl_word(16'd5, 1'b1, 1'b1));

      // R11 new request restarts the count
      send_req(32'h0000_3333, 5'd5, 2'd0);
      @(negedge clk); @(negedge clk);
      send_req(32'h0000_4444, 5'd6, 2'd3);
      watch(99, 1'b0, 20, k, e);
      check("R11 restart cycle", 32'(k), 32'd5);
      cfg_read(2'd1, rd); check("R11 newest addr", rd, 32'h0000_4444);
      cfg_write(2'd0, ctrl_word(16'd5, 1'b1, 1'b1));

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule